// File: doc/BRIEF.md
# Line-to-Message Interrupt Redirection Controller

This block watches a set of interrupt input wires and turns each activation into a posted write message addressed to a processor. Every input has its own redirection entry. The entry sets whether the line is masked, whether it is active high or active low, and whether it is edge- or level-sensitive. It also holds the vector carried as message data and the destination identifiers from which the message address is formed. When several inputs want service at once, a fixed-priority arbiter picks the lowest line number. Only one message is presented on the outbound valid/ready handshake at a time.

Software reaches the block through three byte offsets on a small memory-mapped slave port. An index register at 0x00 selects an internal register. A data window at 0x10 reads and writes the selected register. A write-only acknowledge port at 0x40 takes a vector value. A level-sensitive line that has sent a message stays in service until an acknowledge carrying its vector arrives. If its input is still active at that point, it sends again. An edge-sensitive line records each new activation as pending, even while masked, and sends it once the line is unmasked.

Top module: `irq_msg_redirector`

## Requirements
- R1: A write to byte offset 0x00 sets the 8-bit index, and a read of 0x00 returns it zero-extended. Through the window at 0x10, an index that is neither 0x01 nor a table word reads as zero, and writes to it have no effect.
- R2: Index 0x01 is read-only. Bits 7:0 hold the VERSION parameter, bits 23:16 hold NUM_LINES-1, and all other bits are zero.
- R3: Index 0x10+2n is the low word of line n and 0x11+2n is its high word. A window read returns the last value written. After reset, low words read 0x0001_0000 and high words read 0.
- R4: While low-word bit 16 (mask) is set, the line produces no message.
- R5: With low-word bit 15 clear (edge mode), each inactive-to-active change of the line becomes pending even while masked. The pending change is sent once unmasked, and only once per change. Switching the line to level mode discards a pending change.
- R6: Low-word bit 13 set makes a low input the active state; clear makes a high input active.
- R7: The message address is {MSG_BASE[11:0], high[31:24], high[23:16], low[8], 3'b000}, and the message data is low[7:0] zero-extended.
- R8: With bit 15 set (level mode), a line that has sent is in service and cannot send again until a write to 0x40 arrives whose bits 7:0 equal its vector. A non-matching value has no effect. A matching value while the input is still active causes a new message.
- R9: When several lines request at the same time, messages leave in ascending line order.
- R10: msg_valid, msg_addr and msg_data hold steady until a cycle with msg_ready high.
- R11: After reset, msg_valid is low and bus reads return zero until written state exists.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | ADDR_W | Byte offset of the access |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, registered, one cycle after bus_rd |
| bus_rvalid | output | 1 | Marks bus_rdata valid |
| irq_in | input | NUM_LINES | Asynchronous interrupt inputs |
| msg_valid | output | 1 | Outbound message request |
| msg_ready | input | 1 | Downstream accepts the message |
| msg_addr | output | 32 | Message address |
| msg_data | output | 32 | Message data (vector) |

## Verification
The bench builds the block with six lines, version 0x13 and address base 0xABC. Six lines give a non-power-of-two table, so the index range check sees a boundary just past the last high word at 0x1C. That boundary is compared with neighbours that are valid. The version field then reads back a distinctive entry count, and every message address carries the non-default base. With six lines, the random rounds exercise ordering across mixed subsets, including the top line behind lower ones.

// File: rtl/irq_redir_pkg.sv
package irq_redir_pkg;
  localparam int WORD_W = 32;

  // byte offsets on the slave port
  localparam logic [7:0] OFF_SEL = 8'h00;
  localparam logic [7:0] OFF_WIN = 8'h10;
  localparam logic [7:0] OFF_EOI = 8'h40;

  // internal indices reached through the window
  localparam logic [7:0] IDX_VER = 8'h01;
  localparam logic [7:0] IDX_TBL = 8'h10;

  // low-word control bits
  localparam int B_MASK  = 16;
  localparam int B_LEVEL = 15;
  localparam int B_ALOW  = 13;
  localparam int B_LPRI  = 8;

  localparam logic [WORD_W-1:0] LO_RESET = 32'h0001_0000;

  typedef struct packed {
    logic       mask;
    logic       level;
    logic       act_low;
    logic       lpri;
    logic [7:0] vec;
    logic [7:0] dest_id;
    logic [7:0] dest_eid;
  } line_cfg_t;
endpackage

// File: rtl/irq_redir_regs.sv
module irq_redir_regs
  import irq_redir_pkg::*;
#(
  parameter int         NUM_LINES = 8,
  parameter int         ADDR_W    = 8,
  parameter logic [7:0] VERSION   = 8'h21
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  bus_wr,
  input  logic                  bus_rd,
  input  logic [ADDR_W-1:0]     bus_addr,
  input  logic [WORD_W-1:0]     bus_wdata,
  output logic [WORD_W-1:0]     bus_rdata,
  output logic                  bus_rvalid,
  output line_cfg_t [NUM_LINES-1:0] cfg,
  output logic                  eoi_valid,
  output logic [7:0]            eoi_vec
);
  localparam int         IDX_W   = (NUM_LINES > 1) ? $clog2(NUM_LINES) : 1;
  localparam logic [8:0] TBL_END = 9'(IDX_TBL) + 9'(2 * NUM_LINES);

  logic [WORD_W-1:0] lo_q [NUM_LINES];
  logic [WORD_W-1:0] hi_q [NUM_LINES];
  logic [7:0]        sel_q;

  logic              tbl_hit;
  logic [7:0]        tbl_off;
  logic [IDX_W-1:0]  ent;
  logic              ent_hi;
  logic [WORD_W-1:0] ver_word;
  logic [WORD_W-1:0] win_val;
  logic              wr_sel, wr_win, rd_sel, rd_win;

  assign tbl_hit  = ({1'b0, sel_q} >= 9'(IDX_TBL)) && ({1'b0, sel_q} < TBL_END);
  assign tbl_off  = sel_q - IDX_TBL;
  assign ent      = tbl_off[IDX_W:1];
  assign ent_hi   = tbl_off[0];
  assign ver_word = {8'h00, 8'(NUM_LINES - 1), 8'h00, VERSION};

  assign wr_sel = bus_wr && (bus_addr == ADDR_W'(OFF_SEL));
  assign wr_win = bus_wr && (bus_addr == ADDR_W'(OFF_WIN));
  assign rd_sel = bus_rd && (bus_addr == ADDR_W'(OFF_SEL));
  assign rd_win = bus_rd && (bus_addr == ADDR_W'(OFF_WIN));

  assign eoi_valid = bus_wr && (bus_addr == ADDR_W'(OFF_EOI));
  assign eoi_vec   = bus_wdata[7:0];

  always_comb begin
    if (sel_q == IDX_VER)  win_val = ver_word;
    else if (tbl_hit)      win_val = ent_hi ? hi_q[ent] : lo_q[ent];
    else                   win_val = '0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sel_q      <= '0;
      bus_rdata  <= '0;
      bus_rvalid <= 1'b0;
      for (int i = 0; i < NUM_LINES; i++) begin
        lo_q[i] <= LO_RESET;
        hi_q[i] <= '0;
      end
    end else begin
      if (wr_sel) sel_q <= bus_wdata[7:0];
      if (wr_win && tbl_hit) begin
        if (ent_hi) hi_q[ent] <= bus_wdata;
        else        lo_q[ent] <= bus_wdata;
      end
      bus_rvalid <= bus_rd;
      if (rd_sel)      bus_rdata <= {24'h0, sel_q};
      else if (rd_win) bus_rdata <= win_val;
      else if (bus_rd) bus_rdata <= '0;
    end
  end

  for (genvar g = 0; g < NUM_LINES; g++) begin : g_cfg
    assign cfg[g] = {lo_q[g][B_MASK], lo_q[g][B_LEVEL], lo_q[g][B_ALOW],
                     lo_q[g][B_LPRI], lo_q[g][7:0], hi_q[g][31:24], hi_q[g][23:16]};
  end

  // R2: a window read of the version index returns the constant word
  a_r2_version_ro: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && (bus_addr == ADDR_W'(OFF_WIN)) && (sel_q == IDX_VER) && !wr_sel)
      |=> (bus_rvalid && bus_rdata[7:0] == VERSION && bus_rdata[23:16] == 8'(NUM_LINES - 1)));

  // R1: the select register reads back the index it held
  a_r1_sel_readback: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && (bus_addr == ADDR_W'(OFF_SEL)))
      |=> (bus_rdata == {24'h0, $past(sel_q)}));
endmodule

// File: rtl/irq_redir_line.sv
module irq_redir_line
  import irq_redir_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic      irq_raw,
  input  line_cfg_t cfg,
  input  logic      eoi_valid,
  input  logic [7:0] eoi_vec,
  input  logic      launch,
  output logic      req
);
  logic s1_q, s2_q, act_q, pend_q, svc_q;
  logic act, new_edge, eoi_hit;

  assign act      = s2_q ^ cfg.act_low;
  assign new_edge = act && !act_q;
  assign eoi_hit  = eoi_valid && cfg.level && (eoi_vec == cfg.vec);

  always_ff @(posedge clk) begin
    if (rst) begin
      s1_q   <= 1'b0;
      s2_q   <= 1'b0;
      act_q  <= 1'b0;
      pend_q <= 1'b0;
      svc_q  <= 1'b0;
    end else begin
      s1_q  <= irq_raw;
      s2_q  <= s1_q;
      act_q <= act;

      if (cfg.level)     pend_q <= 1'b0;
      else if (new_edge) pend_q <= 1'b1;
      else if (launch)   pend_q <= 1'b0;

      if (!cfg.level)    svc_q <= 1'b0;
      else if (launch)   svc_q <= 1'b1;
      else if (eoi_hit)  svc_q <= 1'b0;
    end
  end

  assign req = !cfg.mask && (cfg.level ? (act && !svc_q) : pend_q);

  // R8: in-service ends only through a matching acknowledge or leaving level mode
  a_r8_svc_release: assert property (@(posedge clk) disable iff (rst)
    $fell(svc_q) |-> $past(eoi_hit || !cfg.level));

  // R5: a sent edge is consumed unless another edge arrived with it
  a_r5_edge_consumed: assert property (@(posedge clk) disable iff (rst)
    (launch && !cfg.level && !new_edge) |=> !pend_q);
endmodule

// File: rtl/irq_redir_arb.sv
module irq_redir_arb
  import irq_redir_pkg::*;
#(
  parameter int          NUM_LINES = 8,
  parameter logic [11:0] MSG_BASE  = 12'hFEE
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic [NUM_LINES-1:0]      req,
  input  line_cfg_t [NUM_LINES-1:0] cfg,
  input  logic                      msg_ready,
  output logic [NUM_LINES-1:0]      launch,
  output logic                      msg_valid,
  output logic [WORD_W-1:0]         msg_addr,
  output logic [WORD_W-1:0]         msg_data
);
  localparam int IDX_W = (NUM_LINES > 1) ? $clog2(NUM_LINES) : 1;

  logic [NUM_LINES-1:0] grant;
  logic [IDX_W-1:0]     win_idx;
  logic                 found, slot_free;
  line_cfg_t            win_cfg;

  always_comb begin
    grant   = '0;
    win_idx = '0;
    found   = 1'b0;
    for (int i = 0; i < NUM_LINES; i++) begin
      if (req[i] && !found) begin
        grant[i] = 1'b1;
        win_idx  = IDX_W'(i);
        found    = 1'b1;
      end
    end
  end

  assign slot_free = !msg_valid || msg_ready;
  assign launch    = slot_free ? grant : '0;
  assign win_cfg   = cfg[win_idx];

  always_ff @(posedge clk) begin
    if (rst) begin
      msg_valid <= 1'b0;
      msg_addr  <= '0;
      msg_data  <= '0;
    end else if (|launch) begin
      msg_valid <= 1'b1;
      msg_addr  <= {MSG_BASE, win_cfg.dest_id, win_cfg.dest_eid, win_cfg.lpri, 3'b000};
      msg_data  <= {24'h0, win_cfg.vec};
    end else if (msg_ready) begin
      msg_valid <= 1'b0;
    end
  end

  // R9: at most one line is launched per cycle
  a_r9_single_launch: assert property (@(posedge clk) disable iff (rst)
    $onehot0(launch));

  // R10: a stalled message stays put
  a_r10_hold_stable: assert property (@(posedge clk) disable iff (rst)
    (msg_valid && !msg_ready) |=> (msg_valid && $stable(msg_addr) && $stable(msg_data)));
endmodule

// File: rtl/irq_msg_redirector.sv
module irq_msg_redirector
  import irq_redir_pkg::*;
#(
  parameter int          NUM_LINES = 8,
  parameter int          ADDR_W    = 8,
  parameter logic [7:0]  VERSION   = 8'h21,
  parameter logic [11:0] MSG_BASE  = 12'hFEE
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 bus_wr,
  input  logic                 bus_rd,
  input  logic [ADDR_W-1:0]    bus_addr,
  input  logic [31:0]          bus_wdata,
  output logic [31:0]          bus_rdata,
  output logic                 bus_rvalid,
  input  logic [NUM_LINES-1:0] irq_in,
  output logic                 msg_valid,
  input  logic                 msg_ready,
  output logic [31:0]          msg_addr,
  output logic [31:0]          msg_data
);
  line_cfg_t [NUM_LINES-1:0] cfg;
  logic [NUM_LINES-1:0]      req, launch;
  logic                      eoi_valid;
  logic [7:0]                eoi_vec;

  irq_redir_regs #(
    .NUM_LINES(NUM_LINES), .ADDR_W(ADDR_W), .VERSION(VERSION)
  ) u_regs (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .bus_rvalid(bus_rvalid),
    .cfg(cfg), .eoi_valid(eoi_valid), .eoi_vec(eoi_vec)
  );

  for (genvar g = 0; g < NUM_LINES; g++) begin : g_line
    irq_redir_line u_line (
      .clk(clk), .rst(rst), .irq_raw(irq_in[g]), .cfg(cfg[g]),
      .eoi_valid(eoi_valid), .eoi_vec(eoi_vec),
      .launch(launch[g]), .req(req[g])
    );
  end

  irq_redir_arb #(
    .NUM_LINES(NUM_LINES), .MSG_BASE(MSG_BASE)
  ) u_arb (
    .clk(clk), .rst(rst), .req(req), .cfg(cfg), .msg_ready(msg_ready),
    .launch(launch), .msg_valid(msg_valid),
    .msg_addr(msg_addr), .msg_data(msg_data)
  );

  // R11: nothing is offered in the cycle after reset
  a_r11_reset_quiet: assert property (@(posedge clk) rst |=> !msg_valid);
endmodule

// File: tb/irq_msg_redirector_tb.sv
module irq_msg_redirector_tb;
  localparam int          N    = 6;
  localparam logic [7:0]  VER  = 8'h13;
  localparam logic [11:0] BASE = 12'hABC;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_wr = 1'b0, bus_rd = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        bus_rvalid;
  logic [N-1:0] irq_in = '0;
  logic        msg_valid, msg_ready = 1'b0;
  logic [31:0] msg_addr, msg_data;

  int n_chk = 0, n_err = 0;
  logic [31:0] lo_m [N];
  logic [31:0] hi_m [N];

  always #4 clk = ~clk;

  irq_msg_redirector #(.NUM_LINES(N), .ADDR_W(8), .VERSION(VER), .MSG_BASE(BASE)) u_dut (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_rvalid(bus_rvalid),
    .irq_in(irq_in), .msg_valid(msg_valid), .msg_ready(msg_ready),
    .msg_addr(msg_addr), .msg_data(msg_data)
  );

  function automatic logic [31:0] exp_addr(input logic [31:0] hi, input logic [31:0] lo);
    return {BASE, hi[31:24], hi[23:16], lo[8], 3'b000};
  endfunction

  task automatic report();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_err);
    $finish;
  endtask

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic bus_write(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic bus_read(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_rd = 1'b1; bus_addr = a;
    @(negedge clk);
    bus_rd = 1'b0;
    d = bus_rdata;
  endtask

  task automatic win_write(input logic [7:0] idx, input logic [31:0] d);
    bus_write(8'h00, {24'h0, idx});
    bus_write(8'h10, d);
  endtask

  task automatic win_read(input logic [7:0] idx, output logic [31:0] d);
    bus_write(8'h00, {24'h0, idx});
    bus_read(8'h10, d);
  endtask

  task automatic set_line(input int n, input logic [31:0] hi, input logic [31:0] lo);
    hi_m[n] = hi; lo_m[n] = lo;
    win_write(8'(8'h11 + 2 * n), hi);
    win_write(8'(8'h10 + 2 * n), lo);
  endtask

  task automatic expect_msg(input string tag, input int n);
    int waited = 0;
    while (!msg_valid && waited < 40) begin
      @(negedge clk);
      waited++;
    end
    check({tag, " valid"}, {31'h0, msg_valid}, 32'h1);
    check({tag, " addr"}, msg_addr, exp_addr(hi_m[n], lo_m[n]));
    check({tag, " data"}, msg_data, {24'h0, lo_m[n][7:0]});
    msg_ready = 1'b1;
    @(negedge clk);
    msg_ready = 1'b0;
  endtask

  task automatic expect_none(input string tag, input int cycles);
    logic seen = 1'b0;
    for (int i = 0; i < cycles; i++) begin
      @(negedge clk);
      if (msg_valid) seen = 1'b1;
    end
    check(tag, {31'h0, seen}, 32'h0);
  endtask

  task automatic eoi(input logic [7:0] v);
    bus_write(8'h40, {24'h0, v});
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog expired");
    report();
  end

  initial begin
    logic [31:0] rd, lo, hi;
    logic [7:0]  v2, v3, v4;
    logic [N-1:0] subset;
    void'($urandom(32'd20240611));
    for (int i = 0; i < N; i++) begin lo_m[i] = 32'h0001_0000; hi_m[i] = '0; end

    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R11 / R3: reset state
    check("R11 msg_valid after reset", {31'h0, msg_valid}, 32'h0);
    win_read(8'h10, rd); check("R3 reset low word", rd, 32'h0001_0000);
    win_read(8'h11, rd); check("R3 reset high word", rd, 32'h0);
    win_read(8'h1B, rd); check("R3 reset last high word", rd, 32'h0);

    // R1: select readback and unimplemented indices
    bus_write(8'h00, 32'h0000_0005);
    bus_read(8'h00, rd); check("R1 select readback", rd, 32'h5);
    bus_write(8'h10, 32'hDEAD_BEEF);
    bus_read(8'h10, rd); check("R1 unimplemented index reads zero", rd, 32'h0);
    win_write(8'h1C, 32'h1234_5678);
    win_read(8'h1C, rd); check("R1 index past table ignored", rd, 32'h0);
    win_read(8'h1B, rd); check("R1 last table word untouched", rd, 32'h0);

    // R2: version register
    win_read(8'h01, rd); check("R2 version word", rd, {8'h0, 8'(N - 1), 8'h0, VER});
    win_write(8'h01, 32'hFFFF_FFFF);
    win_read(8'h01, rd); check("R2 version read-only", rd, {8'h0, 8'(N - 1), 8'h0, VER});

    // R3: random table words, all masked
    for (int n = 0; n < N; n++) begin
      lo = $urandom | 32'h0001_0000;
      hi = $urandom;
      set_line(n, hi, lo);
    end
    for (int n = 0; n < N; n++) begin
      win_read(8'(8'h10 + 2 * n), rd); check("R3 low readback", rd, lo_m[n]);
      win_read(8'(8'h11 + 2 * n), rd); check("R3 high readback", rd, hi_m[n]);
    end
    expect_none("R4 masked random entries silent", 10);
    for (int n = 0; n < N; n++) set_line(n, 32'h0, 32'h0001_8000);
    expect_none("R5 level mode drops stale edges", 10);

    // R4 / R7 / R8: level line 2
    v2 = 8'(($urandom & 8'hF8) | 8'h02);
    irq_in[2] = 1'b1;
    set_line(2, 32'h5AC3_0000, 32'h0001_8100 | {24'h0, v2});
    expect_none("R4 masked level line silent", 12);
    set_line(2, hi_m[2], 32'h0000_8100 | {24'h0, v2});
    expect_msg("R7 message fields line 2", 2);
    expect_none("R8 no refire while in service", 12);
    eoi(v2 ^ 8'h01);
    expect_none("R8 mismatched ack ignored", 12);
    eoi(v2);
    expect_msg("R8 refire after ack with input active", 2);
    irq_in[2] = 1'b0;
    repeat (5) @(negedge clk);
    eoi(v2);
    expect_none("R8 ack with input idle silent", 12);

    // R6: active-low level line 3
    v3 = 8'h63;
    irq_in[3] = 1'b1;
    set_line(3, 32'h1177_0000, 32'h0000_A000 | {24'h0, v3});
    expect_none("R6 active-low idle while high", 10);
    irq_in[3] = 1'b0;
    expect_msg("R6 active-low fires on low input", 3);
    irq_in[3] = 1'b1;
    repeat (5) @(negedge clk);
    eoi(v3);
    expect_none("R6 released after ack", 10);

    // R5: edge line 4
    v4 = 8'h84;
    set_line(4, 32'h2233_0000, 32'h0001_0000 | {24'h0, v4});
    @(negedge clk); irq_in[4] = 1'b1;
    repeat (2) @(negedge clk); irq_in[4] = 1'b0;
    expect_none("R5 masked edge held", 12);
    set_line(4, hi_m[4], 32'h0000_0000 | {24'h0, v4});
    expect_msg("R5 pending edge sent on unmask", 4);
    expect_none("R5 one message per edge", 12);
    irq_in[4] = 1'b1;
    repeat (2) @(negedge clk); irq_in[4] = 1'b0;
    expect_msg("R5 second edge", 4);
    expect_none("R5 no extra after second edge", 10);

    // R9 / R10: simultaneous lines 0, 1, 5
    set_line(0, 32'h0A0B_0000, 32'h0000_8010);
    set_line(1, 32'h0C0D_0000, 32'h0000_8111);
    set_line(5, 32'h0E0F_0000, 32'h0000_8015);
    @(negedge clk);
    irq_in[0] = 1'b1; irq_in[1] = 1'b1; irq_in[5] = 1'b1;
    while (!msg_valid) @(negedge clk);
    for (int k = 0; k < 5; k++) begin
      @(negedge clk);
      check("R10 held addr while stalled", msg_addr, exp_addr(hi_m[0], lo_m[0]));
    end
    check("R10 still valid while stalled", {31'h0, msg_valid}, 32'h1);
    expect_msg("R9 order first line 0", 0);
    expect_msg("R9 order second line 1", 1);
    expect_msg("R9 order third line 5", 5);
    irq_in[0] = 1'b0; irq_in[1] = 1'b0; irq_in[5] = 1'b0;
    repeat (5) @(negedge clk);
    eoi(8'h10); eoi(8'h11); eoi(8'h15);
    expect_none("R8 all released", 8);

    // random rounds, level lines, ascending order
    for (int n = 0; n < N; n++) set_line(n, 32'h0, 32'h0001_8000);
    irq_in = '0;
    repeat (6) @(negedge clk);
    for (int r = 0; r < 20; r++) begin
      for (int n = 0; n < N; n++) begin
        lo = 32'h0000_8000 | ($urandom & 32'h100) | {24'h0, 5'($urandom), 3'(n)};
        set_line(n, $urandom & 32'hFFFF_0000, lo);
      end
      subset = N'($urandom);
      if (subset == '0) subset = N'(1) << (r % N);
      @(negedge clk);
      irq_in = subset;
      for (int n = 0; n < N; n++)
        if (subset[n]) expect_msg("R9 random ascending order", n);
      expect_none("R8 random no refire", 4);
      irq_in = '0;
      repeat (5) @(negedge clk);
      for (int n = 0; n < N; n++)
        if (subset[n]) eoi(lo_m[n][7:0]);
      expect_none("R8 random released", 4);
    end

    report();
  end
endmodule